// File: doc/BRIEF.md
# Bitmap RAM Address Sequencer

This block receives a byte-wide stream of host writes aimed at a bitmap memory of 64 rows by 256 pixel columns. The memory is held as 1024 words of 16 bits, 16 words to a row. Each byte arrives with a qualifier. The qualifier marks the byte as a command or as data.

A set-address command opens a short address phase. The command byte that follows sets the row, and the next command byte sets the word column. After that, each pair of data bytes forms one 16-bit word. The high half comes first. The finished word is stored at the current row and column, and the column then steps forward by one.

After each stored word, a busy output stays high for a fixed two cycles. Bytes written during that window are dropped. A read-back port gives the content of any word at any time, without waiting for a clock edge.

Top module: `bmp_addr_seq`

## Requirements
- R1: After reset, busy is low, the row and the column are both 0, and no high byte is pending. A data pair written before any set-address command is stored at row 0, column 0.
- R2: A command byte equal to 8'h80 (the set-address opcode), given while no address phase is open, opens an address phase. The next accepted command byte loads the row from its bits 5:0. The command byte after that loads the column from its bits 3:0. The upper bits of both bytes are ignored.
- R3: In the data phase, the first data byte becomes bits 15:8 of a word and the second becomes bits 7:0. The word is written at the current row and column on the clock edge that accepts the second byte.
- R4: After each stored word, the column increases by one. It wraps from 15 to 0 and the row stays the same.
- R5: busy is high for exactly the two clock cycles after the edge that stores a word, and low otherwise.
- R6: Any byte offered while busy is high is dropped. It does not change the address, the pending byte or the memory.
- R7: A set-address command that arrives after the high byte and before the low byte discards the pending high byte.
- R8: During the data phase, a command byte other than 8'h80 has no effect. During the address phase, data bytes have no effect.
- R9: rdWord always shows the stored word at row rdRow and column rdCol, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Byte write strobe, one byte per cycle |
| isCmd | input | 1 | 1: the byte is a command; 0: the byte is data |
| wrByte | input | 8 | Byte written by the host |
| busy | output | 1 | High while a stored word blocks new writes |
| rdRow | input | 6 | Read-back row |
| rdCol | input | 4 | Read-back word column |
| rdWord | output | 16 | Word stored at rdRow and rdCol |

## Verification
Several kinds of wrong internal state show up at the ports:
- A wrong phase of the address sequence, or a wrong column count, puts words at the wrong row or column. Reading back the whole memory shows this at the first misplaced word.
- A stale or lost high byte corrupts the upper half of the next stored word.
- A wrong busy counter shows on busy within one to three cycles of the commit edge. The bytes that leak through or get dropped as a result then show in the next word read back.

The bench fills every row with a column start that differs from row to row, and forces a wrap in each row. It then reads all 1024 words and compares each against values it computes itself.

// File: rtl/bmp_seq_pkg.sv
package bmp_seq_pkg;

  // Number of cycles busy stays high after a word is stored
  localparam int BUSY_CYCLES = 2;

  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_ROW  = 2'd1,
    ST_COL  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic loadRow;
    logic loadCol;
    logic loadHi;
    logic commit;
  } seqStrobe_t;

endpackage

// File: rtl/bmp_seq_ctrl.sv
module bmp_seq_ctrl
  import bmp_seq_pkg::*;
#(
  parameter int          BYTE_W      = 8,
  parameter logic [7:0]  ADDR_OPCODE = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              isCmd,
  input  logic [BYTE_W-1:0] wrByte,
  output seqStrobe_t        strobe,
  output logic              busy
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  seqState_t        state;
  logic             hiValid;
  logic [CNT_W-1:0] busyCnt;
  logic             accept;
  logic             addrCmd;

  assign busy    = (busyCnt != '0);
  assign accept  = wrEn && !busy;
  assign addrCmd = accept && isCmd && (state == ST_DATA)
                   && (wrByte == BYTE_W'(ADDR_OPCODE));

  always_comb begin
    strobe = '0;
    if (accept) begin
      unique case (state)
        ST_ROW:  strobe.loadRow = isCmd;
        ST_COL:  strobe.loadCol = isCmd;
        default: begin
          if (!isCmd) begin
            if (hiValid) strobe.commit = 1'b1;
            else         strobe.loadHi = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_DATA;
      hiValid <= 1'b0;
      busyCnt <= '0;
    end else begin
      if (addrCmd)             state <= ST_ROW;
      else if (strobe.loadRow) state <= ST_COL;
      else if (strobe.loadCol) state <= ST_DATA;

      if (addrCmd)            hiValid <= 1'b0;
      else if (strobe.loadHi) hiValid <= 1'b1;
      else if (strobe.commit) hiValid <= 1'b0;

      if (strobe.commit)      busyCnt <= CNT_W'(BUSY_CYCLES);
      else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
    end
  end

  AST_COMMIT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> busy);                                        // R5
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy);                                          // R5
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |=> !busy);                               // R5
  AST_DROP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (strobe == '0));                                       // R6
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));                                              // R8
  AST_ADDR_DROPS_HI: assert property (@(posedge clk) disable iff (!rstN)
    addrCmd |=> !hiValid);                                          // R7

endmodule

// File: rtl/bmp_seq_dpath.sv
module bmp_seq_dpath
  import bmp_seq_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int ROWS      = 64,
  parameter int ROW_WORDS = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  seqStrobe_t                   strobe,
  input  logic [BYTE_W-1:0]            wrByte,
  input  logic [$clog2(ROWS)-1:0]      rdRow,
  input  logic [$clog2(ROW_WORDS)-1:0] rdCol,
  output logic [2*BYTE_W-1:0]          rdWord
);

  localparam int ROW_W  = $clog2(ROWS);
  localparam int COL_W  = $clog2(ROW_WORDS);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int DEPTH  = ROWS * ROW_WORDS;

  logic [ROW_W-1:0]  rowAddr;
  logic [COL_W-1:0]  colAddr;
  logic [BYTE_W-1:0] hiByte;
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowAddr <= '0;
      colAddr <= '0;
      hiByte  <= '0;
    end else begin
      if (strobe.loadRow) rowAddr <= wrByte[ROW_W-1:0];
      if (strobe.loadCol) colAddr <= wrByte[COL_W-1:0];
      else if (strobe.commit) colAddr <= colAddr + 1'b1;
      if (strobe.loadHi) hiByte <= wrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.commit) mem[{rowAddr, colAddr}] <= {hiByte, wrByte};
  end

  assign rdWord = mem[{rdRow, rdCol}];

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> colAddr == COL_W'($past(colAddr) + 1'b1));    // R4
  AST_ROW_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> $stable(rowAddr));                            // R4

endmodule

// File: rtl/bmp_addr_seq.sv
module bmp_addr_seq
  import bmp_seq_pkg::*;
#(
  parameter int          BYTE_W      = 8,
  parameter int          ROWS        = 64,
  parameter int          ROW_WORDS   = 16,
  parameter logic [7:0]  ADDR_OPCODE = 8'h80
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic                         isCmd,
  input  logic [BYTE_W-1:0]            wrByte,
  output logic                         busy,
  input  logic [$clog2(ROWS)-1:0]      rdRow,
  input  logic [$clog2(ROW_WORDS)-1:0] rdCol,
  output logic [2*BYTE_W-1:0]          rdWord
);

  seqStrobe_t strobe;

  bmp_seq_ctrl #(
    .BYTE_W     (BYTE_W),
    .ADDR_OPCODE(ADDR_OPCODE)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .isCmd (isCmd),
    .wrByte(wrByte),
    .strobe(strobe),
    .busy  (busy)
  );

  bmp_seq_dpath #(
    .BYTE_W   (BYTE_W),
    .ROWS     (ROWS),
    .ROW_WORDS(ROW_WORDS)
  ) dpath_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrByte(wrByte),
    .rdRow (rdRow),
    .rdCol (rdCol),
    .rdWord(rdWord)
  );

endmodule

// File: tb/bmp_addr_seq_tb_top.sv
module bmp_addr_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        isCmd = 1'b0;
  logic [7:0]  wrByte = '0;
  logic        busy;
  logic [5:0]  rdRow = '0;
  logic [3:0]  rdCol = '0;
  logic [15:0] rdWord;

  int errors = 0;
  int checks = 0;
  logic [15:0] expMem [1024];

  always #10 clk = ~clk;

  bmp_addr_seq dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .isCmd(isCmd), .wrByte(wrByte),
    .busy(busy), .rdRow(rdRow), .rdCol(rdCol), .rdWord(rdWord)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic sendByte(input logic c, input logic [7:0] b);
    wrEn = 1'b1; isCmd = c; wrByte = b;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Stores one word and checks the busy window (R5)
  task automatic putWord(input logic [15:0] w);
    sendByte(1'b0, w[15:8]);
    sendByte(1'b0, w[7:0]);
    chk("R5 busy cycle 1", busy, 1);
    @(negedge clk);
    chk("R5 busy cycle 2", busy, 1);
    @(negedge clk);
    chk("R5 busy released", busy, 0);
  endtask

  task automatic setAddr(input logic [7:0] r, input logic [7:0] c);
    sendByte(1'b1, 8'h80);
    sendByte(1'b1, r);
    sendByte(1'b1, c);
  endtask

  task automatic readChk(input string req, input int r, input int c, input logic [15:0] e);
    rdRow = 6'(r); rdCol = 4'(c);
    #1;
    chk(req, rdWord, e);
  endtask

  function automatic logic [15:0] pat(input int r, input int c, input int pass);
    int v;
    v = (r * 16 + c) * 40503 + pass * 1445 + 17;
    return v[15:0];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 busy after reset", busy, 0);
    // R1: write without address goes to row 0, col 0
    putWord(16'hBEEF);
    readChk("R1 first word at origin", 0, 0, 16'hBEEF);

    // R2 R3 R4 R9: sweep all rows, varied start column, forced wrap
    for (int r = 0; r < 64; r++) begin
      int start;
      start = (r * 5) % 16;
      setAddr(8'(r | ((r % 4) << 6)), 8'(start | ((r % 2) * 8'hF0)));
      for (int k = 0; k < 17; k++) begin
        int c;
        c = (start + k) % 16;
        putWord(pat(r, c, k / 16));
        expMem[r * 16 + c] = pat(r, c, k / 16);
      end
    end
    for (int r = 0; r < 64; r++)
      for (int c = 0; c < 16; c++)
        readChk("R4 R2 R3 R9 sweep readback", r, c, expMem[r * 16 + c]);

    // R6: bytes during busy are dropped
    setAddr(8'd10, 8'd3);
    sendByte(1'b0, 8'h11);
    sendByte(1'b0, 8'h22);
    chk("R6 busy set", busy, 1);
    sendByte(1'b0, 8'h77);
    sendByte(1'b1, 8'h80);
    chk("R6 busy clear", busy, 0);
    putWord(16'h3344);
    readChk("R6 word before window", 10, 3, 16'h1122);
    readChk("R6 next word unaffected", 10, 4, 16'h3344);
    readChk("R6 neighbour untouched", 10, 5, expMem[10 * 16 + 5]);

    // R7: address command discards pending high byte
    setAddr(8'd20, 8'd7);
    sendByte(1'b0, 8'hAA);
    setAddr(8'd20, 8'd7);
    putWord(16'h1234);
    readChk("R7 pending high dropped", 20, 7, 16'h1234);

    // R8: foreign command ignored in data phase, data ignored in address phase
    setAddr(8'd33, 8'd15);
    sendByte(1'b1, 8'h01);
    putWord(16'h5A5A);
    readChk("R8 stray command ignored", 33, 15, 16'h5A5A);
    sendByte(1'b1, 8'h80);
    sendByte(1'b1, 8'd40);
    sendByte(1'b0, 8'h99);
    sendByte(1'b1, 8'd2);
    putWord(16'hC0DE);
    readChk("R8 data in address phase ignored", 40, 2, 16'hC0DE);
    readChk("R8 row 33 wrapped col intact", 33, 0, expMem[33 * 16]);
    sendByte(1'b0, 8'h01);
    sendByte(1'b1, 8'h05);
    sendByte(1'b0, 8'h02);
    readChk("R8 command between halves ignored", 40, 3, 16'h0102);
    @(negedge clk); @(negedge clk);
    chk("R5 idle busy low", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule